// File: doc/BRIEF.md
# Pseudo-random Memory Sweep Tester

This block tests a region of memory by visiting it in a scrambled but repeatable order. A right-shifting Galois shift register supplies the order. On each step the register's state is added to a base address, and the block accesses the resulting address only when it falls on a word boundary. Addresses that do not fall on a word boundary cost one cycle and cause no access.

A run has two passes. The first pass writes to every accepted address a word that is computed from the address itself. The second pass reseeds the register, replays the same order and reads each accepted address back. Each read word is compared with the value recomputed from its address. Mismatches are counted in a saturating counter, and the block keeps the address and data of the first failure. A pulse on start launches a run. The block raises busy for the whole run and pulses done for one cycle at the end.

Top module: `lfsr_mem_tester`

## Requirements
- R1: A start pulse is accepted only while busy is low, and busy rises on the next cycle. A start pulse while busy is high is ignored: the run is not restarted and only one done pulse occurs.
- R2: Each pass seeds the register with 1. Each step computes the next state as (state >> 1) XOR (TAP_MASK if the old bit 0 was 1, else 0). A pass ends when the next state would be 1, so it covers all 2^LFSR_W-1 nonzero states exactly once. The state is never zero.
- R3: The address of a step is the base (latched at start) plus the state. It is accessed only if its low log2(WORD_BYTES) bits are zero. Any other address is skipped with mem_we and mem_re both low.
- R4: The data written to address A is A XOR DATA_KEY, taken to DATA_W bits.
- R5: Every accepted address is written exactly once, and all writes come before the first read of the run.
- R6: The read pass issues one mem_re per accepted address, in the same order as the write pass. A read issue is followed by at least one cycle without an issue.
- R7: mem_rdata is compared RD_LAT cycles after the cycle in which mem_re was high. Each mismatch increments err_cnt, which holds at its all-ones value.
- R8: err_first_addr and err_first_data capture the address and read data of the first mismatch of a run. Later mismatches leave them unchanged.
- R9: done is high for exactly one cycle, and busy is low after it. A run lasts 2*(2^LFSR_W-1) + N*RD_LAT + 1 busy cycles, where N is the number of accepted addresses.
- R10: A new start clears err_cnt, err_flag and the first-failure registers.
- R11: err_flag is high exactly when err_cnt is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run launch pulse |
| base_addr | input | ADDR_W | Region base, latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after mem_re |
| err_flag | output | 1 | At least one mismatch this run |
| err_cnt | output | ERR_W | Saturating mismatch count |
| err_first_addr | output | ADDR_W | Address of first mismatch |
| err_first_data | output | DATA_W | Data read at first mismatch |

## Verification
The bench builds the tester with a 6-bit register, mask 0x30, 4-byte words, a read latency of 2 and a 2-bit error counter. With these values a whole pass is only 63 steps. The bench can therefore log every access and compare it with the complete sequence computed from the stepping rule. The runs use an aligned base and a misaligned base, so two different sets of offsets are accepted. The narrow counter lets four injected faults drive it to saturation.

// File: rtl/lfsr_tester_pkg.sv
package lfsr_tester_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WRITE    = 3'd1,
        ST_RD_ISSUE = 3'd2,
        ST_RD_CHECK = 3'd3,
        ST_DONE     = 3'd4
    } tester_state_e;

    typedef struct packed {
        logic seed_load;
        logic advance;
        logic wr;
        logic rd;
        logic chk;
        logic clr;
    } ctrl_t;

endpackage

// File: rtl/galois_stepper.sv
module galois_stepper #(
    parameter int            W    = 22,
    parameter logic [W-1:0]  MASK = 22'h300000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic         advance,
    output logic [W-1:0] state,
    output logic         wrap
);
    localparam logic [W-1:0] SEED = W'(1);

    logic [W-1:0] st_q;
    logic [W-1:0] st_nxt;

    always_comb begin
        st_nxt = (st_q >> 1) ^ (st_q[0] ? MASK : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || seed_load) st_q <= SEED;
        else if (advance)     st_q <= st_nxt;
    end

    assign state = st_q;
    assign wrap  = (st_nxt == SEED);

    // R2
    state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);

    // R2
    seed_value_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (st_q == SEED));

endmodule

// File: rtl/tester_fsm.sv
module tester_fsm
    import lfsr_tester_pkg::*;
#(
    parameter int RD_LAT = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  aligned,
    input  logic  wrap,
    output ctrl_t ctrl,
    output logic  busy,
    output logic  done
);
    localparam int LAT_W = $clog2(RD_LAT + 1);

    tester_state_e st_q, st_d;
    logic [LAT_W-1:0] lat_q;
    logic lat_hit;

    assign lat_hit = (lat_q == LAT_W'(RD_LAT));

    always_comb begin
        st_d = st_q;
        ctrl = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    ctrl.seed_load = 1'b1;
                    ctrl.clr       = 1'b1;
                    st_d           = ST_WRITE;
                end
            end
            ST_WRITE: begin
                ctrl.wr      = aligned;
                ctrl.advance = 1'b1;
                if (wrap) st_d = ST_RD_ISSUE;
            end
            ST_RD_ISSUE: begin
                if (aligned) begin
                    ctrl.rd = 1'b1;
                    st_d    = ST_RD_CHECK;
                end else begin
                    ctrl.advance = 1'b1;
                    if (wrap) st_d = ST_DONE;
                end
            end
            ST_RD_CHECK: begin
                if (lat_hit) begin
                    ctrl.chk     = 1'b1;
                    ctrl.advance = 1'b1;
                    st_d         = wrap ? ST_DONE : ST_RD_ISSUE;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            lat_q <= '0;
        end else begin
            st_q <= st_d;
            if (ctrl.rd)                  lat_q <= LAT_W'(1);
            else if (st_q == ST_RD_CHECK) lat_q <= lat_q + LAT_W'(1);
        end
    end

    assign busy = (st_q != ST_IDLE);
    assign done = (st_q == ST_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R6
    issue_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.rd |=> !ctrl.rd);

    // R5
    no_dual_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.wr && ctrl.rd));

endmodule

// File: rtl/err_tracker.sv
module err_tracker #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          chk,
    input  logic          mismatch,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] first_addr,
    output logic [DW-1:0] first_data
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic hit;
    assign hit = chk && mismatch;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt        <= '0;
            first_addr <= '0;
            first_data <= '0;
        end else if (hit) begin
            if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
            if (cnt == '0) begin
                first_addr <= addr;
                first_data <= rdata;
            end
        end
    end

    // R7
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

    // R8
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt != '0) |=> ($stable(first_addr) && $stable(first_data)));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/lfsr_mem_tester.sv
module lfsr_mem_tester
    import lfsr_tester_pkg::*;
#(
    parameter int                 LFSR_W     = 22,
    parameter logic [LFSR_W-1:0]  TAP_MASK   = 22'h300000,
    parameter int                 ADDR_W     = 32,
    parameter int                 DATA_W     = 32,
    parameter int                 WORD_BYTES = 4,
    parameter int                 RD_LAT     = 1,
    parameter int                 ERR_W      = 16,
    parameter logic [DATA_W-1:0]  DATA_KEY   = 32'h5A3C_96E1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              err_flag,
    output logic [ERR_W-1:0]  err_cnt,
    output logic [ADDR_W-1:0] err_first_addr,
    output logic [DATA_W-1:0] err_first_data
);
    localparam int ALIGN_W = $clog2(WORD_BYTES);

    function automatic logic [DATA_W-1:0] word_for(input logic [ADDR_W-1:0] a);
        return DATA_W'(a) ^ DATA_KEY;
    endfunction

    ctrl_t             ctrl;
    logic [LFSR_W-1:0] lfsr_state;
    logic              wrap;
    logic              aligned;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              mismatch;

    galois_stepper #(.W(LFSR_W), .MASK(TAP_MASK)) u_step (
        .clk       (clk),
        .rst       (rst),
        .seed_load (ctrl.seed_load),
        .advance   (ctrl.advance),
        .state     (lfsr_state),
        .wrap      (wrap)
    );

    tester_fsm #(.RD_LAT(RD_LAT)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .aligned (aligned),
        .wrap    (wrap),
        .ctrl    (ctrl),
        .busy    (busy),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            rd_addr_q <= '0;
        end else begin
            if (ctrl.seed_load) base_q    <= base_addr;
            if (ctrl.rd)        rd_addr_q <= cur_addr;
        end
    end

    assign cur_addr = base_q + ADDR_W'(lfsr_state);

    generate
        if (ALIGN_W == 0) begin : g_byte_grain
            assign aligned = 1'b1;
        end else begin : g_word_grain
            assign aligned = (cur_addr[ALIGN_W-1:0] == '0);
        end
    endgenerate

    assign mem_addr  = cur_addr;
    assign mem_we    = ctrl.wr;
    assign mem_re    = ctrl.rd;
    assign mem_wdata = word_for(cur_addr);
    assign mismatch  = (mem_rdata != word_for(rd_addr_q));

    err_tracker #(.AW(ADDR_W), .DW(DATA_W), .CW(ERR_W)) u_err (
        .clk        (clk),
        .rst        (rst),
        .clr        (ctrl.clr),
        .chk        (ctrl.chk),
        .mismatch   (mismatch),
        .addr       (rd_addr_q),
        .rdata      (mem_rdata),
        .cnt        (err_cnt),
        .first_addr (err_first_addr),
        .first_data (err_first_data)
    );

    assign err_flag = (err_cnt != '0);

    // R1
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !err_flag);

endmodule

// File: tb/tb_lfsr_mem_tester.sv
module tb_lfsr_mem_tester;
    localparam int        LW    = 6;
    localparam logic [5:0] MASK = 6'h30;
    localparam int        AW    = 16;
    localparam int        DW    = 16;
    localparam int        LAT   = 2;
    localparam int        EW    = 2;
    localparam logic [15:0] KEY = 16'hA5C3;
    localparam logic [15:0] FLIP = 16'h0100;
    localparam int        STEPS = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic busy, done, mem_we, mem_re, err_flag;
    logic [AW-1:0] mem_addr, err_first_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, err_first_data;
    logic [EW-1:0] err_cnt;

    always #4 clk = ~clk;

    lfsr_mem_tester #(
        .LFSR_W(LW), .TAP_MASK(MASK), .ADDR_W(AW), .DATA_W(DW),
        .WORD_BYTES(4), .RD_LAT(LAT), .ERR_W(EW), .DATA_KEY(KEY)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .err_flag(err_flag), .err_cnt(err_cnt),
        .err_first_addr(err_first_addr), .err_first_data(err_first_data)
    );

    // behavioural memory with fixed read latency and fault injection
    logic [DW-1:0] mem [64];
    logic          bad [64];
    logic [DW-1:0] pipe [LAT];
    logic [5:0]    moff;
    assign moff = 6'(mem_addr - base_addr);
    assign mem_rdata = pipe[LAT-1];

    always @(posedge clk) begin
        if (mem_we) mem[moff] <= mem_wdata;
        pipe[0] <= mem_re ? (mem[moff] ^ (bad[moff] ? FLIP : 16'h0)) : 16'h0;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end

    // access monitor
    logic [AW-1:0] wl_a [128];
    logic [DW-1:0] wl_d [128];
    logic [AW-1:0] rl_a [128];
    int wn, rn, busy_cyc, done_cnt, done_len, order_bad;
    logic done_prev;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wn < 128) begin wl_a[wn] = mem_addr; wl_d[wn] = mem_wdata; end
                wn++;
                if (rn > 0) order_bad++;
            end
            if (mem_re) begin
                if (rn < 128) rl_a[rn] = mem_addr;
                rn++;
            end
            if (busy) busy_cyc++;
            if (done) begin done_cnt++; if (done_prev) done_len++; end
            done_prev = done;
        end
    end

    int total = 0, fails = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 40000 && !finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // expected sequence from the stepping rule
    logic [LW-1:0] seq [STEPS];
    initial begin
        logic [LW-1:0] s;
        s = 1;
        for (int i = 0; i < STEPS; i++) begin
            seq[i] = s;
            s = (s >> 1) ^ (s[0] ? MASK : 6'h0);
        end
    end

    task automatic run(input logic [AW-1:0] base, input bit poke_busy);
        wn = 0; rn = 0; busy_cyc = 0; done_cnt = 0; done_len = 0; order_bad = 0;
        done_prev = 0;
        base_addr = base;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1, "R1 busy after start", busy, 1);
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            start = 1; base_addr = base ^ 16'h0040;
            @(negedge clk); start = 0;
            repeat (80) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_run(input logic [AW-1:0] base, input string tag);
        int n_al, k, ok_w, ok_r;
        logic [AW-1:0] a;
        n_al = 0; ok_w = 1; ok_r = 1;
        for (int i = 0; i < STEPS; i++) begin
            a = base + AW'(seq[i]);
            if (a[1:0] == 2'b00) begin
                if (n_al < 128) begin
                    if (wl_a[n_al] != a || wl_d[n_al] != (a ^ KEY)) ok_w = 0;
                    if (rl_a[n_al] != a) ok_r = 0;
                end
                n_al++;
            end
        end
        k = n_al;
        chk(wn == k, {"R3 R5 write count ", tag}, wn, k);
        chk(ok_w == 1, {"R2 R3 R4 write order/data ", tag}, ok_w, 1);
        chk(order_bad == 0, {"R5 writes before reads ", tag}, order_bad, 0);
        chk(rn == k && ok_r == 1, {"R6 read order ", tag}, rn, k);
        chk(done_cnt == 1 && done_len == 0, {"R9 single done ", tag}, done_cnt, 1);
        chk(busy_cyc == 2 * STEPS + k * LAT + 1, {"R9 run length ", tag},
            busy_cyc, 2 * STEPS + k * LAT + 1);
        chk(busy == 0, {"R9 idle after ", tag}, busy, 0);
    endtask

    initial begin
        int distinct;
        for (int i = 0; i < 64; i++) begin bad[i] = 0; mem[i] = '0; end
        for (int i = 0; i < LAT; i++) pipe[i] = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "reset busy/done", {busy, done}, 0);
        chk(err_cnt == 0 && err_flag == 0, "R11 reset errors", err_cnt, 0);
        chk(mem_we == 0 && mem_re == 0, "reset strobes", {mem_we, mem_re}, 0);

        // R2: full-length sequence covers each nonzero state once
        distinct = 0;
        for (int v = 1; v < 64; v++)
            for (int i = 0; i < STEPS; i++) if (seq[i] == 6'(v)) distinct++;
        chk(distinct == STEPS, "R2 sequence coverage", distinct, STEPS);

        // clean run, aligned base, with start pulses while busy (R1)
        run(16'h1000, 1);
        check_run(16'h1000, "aligned");
        chk(err_cnt == 0 && err_flag == 0, "R1 R7 clean run", err_cnt, 0);

        // misaligned base: different accepted set
        run(16'h1002, 0);
        check_run(16'h1002, "offset2");

        // single fault
        bad[8] = 1;
        run(16'h1000, 0);
        chk(err_cnt == 1, "R7 one fault count", err_cnt, 1);
        chk(err_flag == 1, "R11 flag on fault", err_flag, 1);
        chk(err_first_addr == 16'h1008, "R8 first addr", err_first_addr, 16'h1008);
        chk(err_first_data == (16'h1008 ^ KEY ^ FLIP), "R8 first data",
            err_first_data, 16'h1008 ^ KEY ^ FLIP);

        // four faults: saturation and first in read order
        bad[4] = 1; bad[12] = 1; bad[60] = 1;
        run(16'h1000, 0);
        begin
            logic [AW-1:0] fa;
            fa = '0;
            for (int i = STEPS - 1; i >= 0; i--)
                if (seq[i][1:0] == 2'b00 && bad[seq[i]]) fa = 16'h1000 + AW'(seq[i]);
            chk(err_cnt == 3, "R7 saturation", err_cnt, 3);
            chk(err_first_addr == fa, "R8 first in read order", err_first_addr, fa);
            chk(err_first_data == (fa ^ KEY ^ FLIP), "R8 first data later",
                err_first_data, fa ^ KEY ^ FLIP);
        end

        // clean again: errors cleared by new start
        for (int i = 0; i < 64; i++) bad[i] = 0;
        run(16'h1000, 0);
        chk(err_cnt == 0 && err_flag == 0, "R10 R11 cleared on start", err_cnt, 0);
        chk(err_first_addr == 0 && err_first_data == 0, "R10 first regs cleared",
            err_first_addr, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule